// File: doc/BRIEF.md
# Multi-Address I2C Slave Address Matcher

This block is the address-recognition front end of an I2C target. It watches the SCL and SDA lines, notices START, repeated START and STOP, and shifts in the first byte that follows a START. That byte holds a 7-bit address in its upper seven bits and the direction bit in its lowest bit. The address is compared against four programmable slot registers. When any slot accepts the address, the block pulls SDA low for the ninth clock. When no slot accepts it, SDA stays released, which is a NACK.

Each slot is eight bits wide. Bits 7:1 hold the slot's address and bit 0 enables general-call recognition for that slot. A slot that holds all zeros never accepts anything. After reset every slot holds zero, so the target is silent until software programs it. If several slots accept the same byte, the lowest-numbered slot is reported. A general-call hit is flagged on its own output. While `master_mode_i` is high, the block never accepts an address.

The decision is reported once per address byte as a one-cycle strobe. The flag, slot index, general-call flag and direction bit then hold until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i[7:0]` in the slot chosen by `cfg_sel_i`, and bits 31:8 of the write data are ignored. `cfg_rdata_o` returns the selected slot in bits 7:0 and zero in bits 31:8.
- R2: After reset all four slots read 0x00, and no address byte is acknowledged.
- R3: A slot holding 0x00 never accepts any address byte, including 0x00.
- R4: The first byte after a START is taken MSB first. Bits 7:1 form the address, and bit 0 is reported on `rw_o` (1 means read).
- R5: A byte with a nonzero address equal to bits 7:1 of some nonzero slot is accepted. `sda_oe_o` goes high after the SCL fall that ends the eighth bit and goes low after the SCL fall that ends the ninth bit.
- R6: A byte that no slot accepts leaves `sda_oe_o` low through the ninth clock, and `match_o` reads 0.
- R7: The byte 0x00 (address 0, write) is accepted by any slot whose bit 0 is set, and `gc_o` is then high. The byte 0x01 (address 0, read) is never accepted.
- R8: When several slots accept a byte, `match_idx_o` gives the lowest slot number.
- R9: While `master_mode_i` is high, no byte is accepted and `sda_oe_o` stays low.
- R10: `addr_valid_o` pulses for one cycle after the eighth SCL rise. `match_o`, `match_idx_o`, `gc_o` and `rw_o` hold until the next START or STOP, and a STOP clears `match_o`.
- R11: A repeated START during a partial byte discards the bits taken so far and restarts the address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| master_mode_i | input | 1 | Controller is acting as master; slots inactive |
| cfg_we_i | input | 1 | Slot write enable |
| cfg_sel_i | input | 2 | Slot select for write and read |
| cfg_wdata_i | input | 32 | Slot write data |
| cfg_rdata_o | output | 32 | Selected slot read data |
| addr_valid_o | output | 1 | One-cycle strobe: address decision made |
| match_o | output | 1 | Address accepted |
| match_idx_o | output | 2 | Lowest accepting slot |
| gc_o | output | 1 | General-call accepted |
| rw_o | output | 1 | Direction bit of the address byte |

## Verification
The bench targets overlapping slots: two slots share address 0x50 and only one of them has general call enabled. A design with the wrong priority order would report slot 2 instead of slot 1. It would also miss the general call held by slot 2 while slot 0 is empty. The byte 0x01 is sent to catch a design that ignores the direction bit when matching a general call, because such a design would acknowledge a read to address zero. A zeroed slot and a zero address byte are sent together, so a design that compares without checking the empty-slot rule would acknowledge. A repeated START after three bits would expose a design that keeps a stale bit count.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK,
    ST_DONE
  } am_state_e;
endpackage

// File: rtl/i2c_am_bus_mon.sv
module i2c_am_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_d_q, sda_d_q, scl_s, sda_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= scl_i;
          sda_sync_q <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
          sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sync_q[SYNC_STAGES-1];
  assign sda_s = sda_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s;
      sda_d_q <= sda_s;
    end
  end

  // START/STOP: SDA moves while SCL is high on both samples
  assign start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_d_q;
  assign scl_fall_o = ~scl_s & scl_d_q;
  assign sda_o      = sda_s;
endmodule

// File: rtl/i2c_am_regs.sv
module i2c_am_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 8,
  parameter int CFG_W     = 32,
  parameter int IDX_W     = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [IDX_W-1:0]                  sel_i,
  input  logic [CFG_W-1:0]                  wdata_i,
  output logic [CFG_W-1:0]                  rdata_o,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slots_o
);
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slot_q;
  logic unused_hi;

  assign unused_hi = ^wdata_i[CFG_W-1:SLOT_W];

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q[g] <= '0;
        else if (we_i && (sel_i == IDX_W'(g))) slot_q[g] <= wdata_i[SLOT_W-1:0];
      end

      // R1
      write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == IDX_W'(g)) |=> (slot_q[g] == $past(wdata_i[SLOT_W-1:0])));
    end
  endgenerate

  assign rdata_o = {{(CFG_W-SLOT_W){1'b0}}, slot_q[sel_i]};
  assign slots_o = slot_q;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 8,
  parameter int IDX_W     = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slots_i,
  input  logic [SLOT_W-1:0]                 byte_i,
  input  logic                              master_mode_i,
  output logic                              hit_o,
  output logic [IDX_W-1:0]                  idx_o,
  output logic                              gc_o
);
  localparam int ADDR_W = SLOT_W - 1;

  logic [ADDR_W-1:0]    addr;
  logic                 rw_bit, is_gc;
  logic [NUM_SLOTS-1:0] hit_vec, lower_hits;

  assign addr   = byte_i[SLOT_W-1:1];
  assign rw_bit = byte_i[0];
  assign is_gc  = (addr == '0) && !rw_bit;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      logic slot_on, norm_hit, gc_hit;
      assign slot_on  = |slots_i[g];
      assign norm_hit = slot_on && (addr != '0) && (slots_i[g][SLOT_W-1:1] == addr);
      assign gc_hit   = slots_i[g][0] && is_gc;
      assign hit_vec[g] = !master_mode_i && (norm_hit || gc_hit);

      // R3
      empty_slot_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_vec[g] |-> (slots_i[g] != '0));
    end
  endgenerate

  // lowest slot wins: scan downward so the last write is the smallest index
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
  assign gc_o  = hit_o && is_gc;

  assign lower_hits = hit_vec & ((NUM_SLOTS'(1) << idx_o) - NUM_SLOTS'(1));

  // R8
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (lower_hits == '0 && hit_vec[idx_o]));

  // R9
  master_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_mode_i |-> !hit_o);
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] cand_byte_o,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              gc_i,
  output logic              sda_oe_o,
  output logic              valid_o,
  output logic              match_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              gc_o,
  output logic              rw_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  am_state_e         state_q;
  logic [BYTE_W-2:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt_q;

  // byte as it will be once the current bit lands
  assign cand_byte_o = {shift_q, sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      bit_cnt_q <= '0;
      sda_oe_o  <= 1'b0;
      valid_o   <= 1'b0;
      match_o   <= 1'b0;
      idx_o     <= '0;
      gc_o      <= 1'b0;
      rw_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i || stop_i) begin
        state_q   <= start_i ? ST_ADDR : ST_IDLE;
        shift_q   <= '0;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
        match_o   <= 1'b0;
        idx_o     <= '0;
        gc_o      <= 1'b0;
        rw_o      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            shift_q   <= cand_byte_o[BYTE_W-2:0];
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
              state_q <= ST_ACK_SETUP;
              valid_o <= 1'b1;
              match_o <= hit_i;
              idx_o   <= idx_i;
              gc_o    <= gc_i;
              rw_o    <= cand_byte_o[0];
            end
          end
          ST_ACK_SETUP: if (scl_fall_i) begin
            sda_oe_o <= match_o;
            state_q  <= ST_ACK;
          end
          ST_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  ack_only_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> match_o);

  // R7
  gc_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gc_o |-> (match_o && !rw_o));

  // R10
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R10
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!match_o && !sda_oe_o));

  // R6
  nack_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !match_o) |=> !sda_oe_o);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter  int NUM_SLOTS   = 4,
  parameter  int CFG_W       = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             master_mode_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             addr_valid_o,
  output logic             match_o,
  output logic [IDX_W-1:0] match_idx_o,
  output logic             gc_o,
  output logic             rw_o
);
  localparam int SLOT_W = 8;

  logic scl_rise, scl_fall, start, stop, sda_s;
  logic [SLOT_W-1:0] cand_byte;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots;
  logic cmp_hit, cmp_gc;
  logic [IDX_W-1:0] cmp_idx;

  i2c_am_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .sda_o(sda_s)
  );

  i2c_am_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CFG_W(CFG_W), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .slots_o(slots)
  );

  i2c_am_cmp #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_cmp (
    .clk_i, .rst_ni,
    .slots_i(slots), .byte_i(cand_byte), .master_mode_i,
    .hit_o(cmp_hit), .idx_o(cmp_idx), .gc_o(cmp_gc)
  );

  i2c_am_ctrl #(.BYTE_W(SLOT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .sda_i(sda_s),
    .cand_byte_o(cand_byte),
    .hit_i(cmp_hit), .idx_i(cmp_idx), .gc_i(cmp_gc),
    .sda_oe_o, .valid_o(addr_valid_o), .match_o,
    .idx_o(match_idx_o), .gc_o, .rw_o
  );
endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  typedef struct packed {
    logic       ack;
    logic [1:0] idx;
    logic       gc;
    logic       rw;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, mm = 1'b0;
  logic we = 1'b0;
  logic [1:0] sel = '0;
  logic [31:0] wdata = '0;
  logic sda_oe, valid, match, gc, rw;
  logic [1:0] idx;
  logic [31:0] rdata;
  logic sda_line;
  logic [7:0] shadow [4];
  exp_t exp_q [$];
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_addr_match uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .master_mode_i(mm), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .addr_valid_o(valid), .match_o(match), .match_idx_o(idx),
    .gc_o(gc), .rw_o(rw)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
    shadow[s] = d[7:0];
  endtask

  task automatic cfg_check(input logic [1:0] s, input string tag);
    @(negedge clk);
    sel = s;
    #1;
    chk(rdata == {24'h0, shadow[s]}, tag, rdata, {24'h0, shadow[s]});
  endtask

  function automatic exp_t model(input logic [7:0] b, input logic m);
    exp_t e;
    logic [6:0] a;
    a = b[7:1];
    e = '0;
    e.rw = b[0];
    for (int i = 3; i >= 0; i--) begin
      if (!m && ((shadow[i] != 8'h00 && a != 7'h0 && shadow[i][7:1] == a) ||
                 (shadow[i][0] && a == 7'h0 && !b[0]))) begin
        e.ack = 1'b1;
        e.idx = 2'(i);
      end
    end
    e.gc = e.ack && (a == 7'h0);
    return e;
  endfunction

  task automatic put_bit(input logic b);
    sda_drv = b; half();
    scl = 1'b1; half();
    scl = 1'b0; half();
  endtask

  task automatic do_start();
    sda_drv = 1'b0; half();
    scl = 1'b0; half();
  endtask

  task automatic do_rep_start();
    sda_drv = 1'b1; half();
    scl = 1'b1; half();
    sda_drv = 1'b0; half();
    scl = 1'b0; half();
  endtask

  task automatic do_stop();
    sda_drv = 1'b0; half();
    scl = 1'b1; half();
    sda_drv = 1'b1; half();
    // R10: STOP clears the flag
    chk(match == 1'b0, "R10 match after STOP", 32'(match), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input exp_t e);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_drv = 1'b1; half();
    scl = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == e.ack, e.ack ? "R5 ack on ninth clock" : "R6 released on ninth clock",
        32'(sda_oe), 32'(e.ack));
    repeat (4) @(negedge clk);
    scl = 1'b0; half();
    chk(sda_oe == 1'b0, "R5 release after ninth clock", 32'(sda_oe), 0);
  endtask

  task automatic xfer(input logic [7:0] b, input logic m);
    exp_t e;
    mm = m;
    e = model(b, m);
    exp_q.push_back(e);
    do_start();
    send_byte(b, e);
    do_stop();
    mm = 1'b0;
  endtask

  // monitor: compare each decision strobe with the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected decision strobe", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(match == e.ack, "R5 R6 R9 match flag", 32'(match), 32'(e.ack));
        if (e.ack) chk(idx == e.idx, "R8 slot index", 32'(idx), 32'(e.idx));
        chk(gc == e.gc, "R7 general call flag", 32'(gc), 32'(e.gc));
        chk(rw == e.rw, "R4 direction bit", 32'(rw), 32'(e.rw));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    chk(sda_oe == 1'b0 && match == 1'b0, "R2 outputs idle after reset", {30'h0, sda_oe, match}, 0);
    for (int i = 0; i < 4; i++) cfg_check(2'(i), "R2 slot reads zero after reset");
    xfer(8'hA0, 1'b0);  // R2: nothing accepted
    xfer(8'h00, 1'b0);  // R2 R3: general call not accepted by empty slots

    // R1: upper write bits ignored, read returns zero above bit 7
    cfg_write(2'd0, 32'hFFFF_FF00);
    cfg_write(2'd1, 32'hABCD_EFA0);
    cfg_write(2'd2, 32'h1234_56A1);
    cfg_write(2'd3, 32'h0000_0047);
    for (int i = 0; i < 4; i++) cfg_check(2'(i), "R1 slot readback");

    xfer(8'hA0, 1'b0);  // R8: slots 1 and 2 both hold 0x50 -> slot 1
    xfer(8'hA1, 1'b0);  // R4: read direction
    xfer(8'h46, 1'b0);  // R5: slot 3
    xfer(8'h22, 1'b0);  // R6: no slot
    xfer(8'h00, 1'b0);  // R7 R3: slot 0 empty, slot 2 has general call
    xfer(8'h01, 1'b0);  // R7: address 0 with read is refused
    xfer(8'hA0, 1'b1);  // R9: master mode

    // R11: repeated START after three bits
    begin
      exp_t e;
      e = model(8'h47, 1'b0);
      exp_q.push_back(e);
      do_start();
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
      do_rep_start();
      send_byte(8'h47, e);
      chk(match == 1'b1 && idx == 2'd3, "R11 capture restarted", {30'h0, match, idx[0]}, 32'h3);
      do_stop();
    end

    // R3 R8: empty slot 1, slot 2 now takes 0x50
    cfg_write(2'd1, 32'h0000_0000);
    cfg_check(2'd1, "R3 slot cleared");
    xfer(8'hA0, 1'b0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10 every byte produced a decision", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule